// File: doc/BRIEF.md
# Dual Digital Potentiometer Register Controller

This block is the digital side of a two-channel, 256-step digital potentiometer. It is an I2C target sampled by the system clock. Through it, a bus controller sets two 8-bit wiper codes, reads them back, keeps a power-up value for each channel in a modelled non-volatile store, uses thirteen general-purpose non-volatile bytes, and drives a shutdown flag. A wiper code of 00h places the wiper nearest the low terminal and FFh places it nearest the high terminal. The positions in between move monotonically. The analog ladder that turns a code into a resistance lies outside this block.

Every register address selects one of two banks. A mode bit in the access-control register picks the bank. In non-volatile mode, addresses 00h and 01h reach the per-channel initial values. A write there also copies the new value into the live wiper, and the store then stays busy for a programmable number of clock cycles. While the store is busy, writes to the wipers, to the non-volatile bytes and to the control register are refused. In volatile mode, only the live wipers can be reached.

A write transfer sends the device address with R/W = 0, then a register-pointer byte, then any number of data bytes. A read transfer uses a repeated start and the device address with R/W = 1, and returns bytes starting at the current pointer. The pointer advances by one after every data byte.

Top module: `dpot_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 1010 followed by `addr_sel_i[2:0]` (bit 2 first). It leaves SDA released for every other address, the general-call byte 00h included.
- R2: After a matching write address, the block acknowledges every byte by pulling SDA low through the ninth SCL pulse. The first byte after the address loads the register pointer.
- R3: The pointer advances by one after every data byte, whether written or read. A read starts at the pointer left by the write phase. A burst therefore covers consecutive registers.
- R4: After reset, both wiper outputs are 80h, both initial-value bytes read 80h, the control register at 10h reads 40h, and `shutdown_o` is 0.
- R5: With VOL (control bit 7) = 1, writes to 00h/01h change only the wiper (channel A/B), reads return the wiper, and no non-volatile write starts.
- R6: With VOL = 0, a write to 00h/01h stores the initial value and sets the matching wiper output to the same byte.
- R7: Each accepted non-volatile write sets WIP (control bit 5) to 1 for NV_BUSY_CYCLES clock cycles. After that, WIP reads 0.
- R8: While WIP = 1, every write to 00h, 01h, 02h–0Eh and 10h is acknowledged but discarded.
- R9: SHDN (control bit 6) = 0 drives `shutdown_o` to 1. SHDN = 1 drives it to 0.
- R10: Control bits 4..0 always read 0, and writes to bit 5 have no effect.
- R11: Bytes 02h–0Eh hold written data in non-volatile mode. In volatile mode, they read 00h and writes to them are discarded.
- R12: Address 0Fh and addresses 11h–FFh acknowledge writes, discard the data and read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, the data line is pulled low (open-drain) |
| addr_sel_i | input | 3 | Low three bits of the device address |
| wiper_a_o | output | 8 | Channel A wiper code |
| wiper_b_o | output | 8 | Channel B wiper code |
| shutdown_o | output | 1 | High when both potentiometers are shut down |

## Verification
The bus lines pass through a two-flop synchroniser, so each bus event takes effect three to four clock cycles after the SCL or SDA edge. Acknowledge and read data appear on `sda_oe_o` that long after SCL falls. The bench runs each SCL phase for ten clock cycles and samples SDA in the middle of the high phase, well after the data has settled. Wiper, shutdown and control state change at the SCL fall that ends the eighth data bit. The bench checks these outputs only after the stop condition. A non-volatile write stays busy for thousands of cycles, so the bench places its refused writes and WIP reads inside that window and waits past it before it expects WIP to be 0.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam int          BYTE_W      = 8;
  localparam logic [3:0]  DEV_PREFIX  = 4'b1010;
  localparam logic [7:0]  ADR_CH_A    = 8'h00;
  localparam logic [7:0]  ADR_CH_B    = 8'h01;
  localparam logic [7:0]  ADR_GP_LO   = 8'h02;
  localparam logic [7:0]  ADR_GP_HI   = 8'h0E;
  localparam logic [7:0]  ADR_CTRL    = 8'h10;
  localparam int          NV_BYTES    = 15;

  typedef enum logic [2:0] {
    T_IDLE, T_ADDR, T_AACK, T_WRX, T_WACK, T_TX, T_TACK
  } tgt_st_e;

  typedef enum logic [2:0] {
    RG_CH_A, RG_CH_B, RG_GP, RG_CTRL, RG_NONE
  } region_e;

  function automatic region_e region_of(input logic [7:0] a);
    if (a == ADR_CH_A)                        return RG_CH_A;
    else if (a == ADR_CH_B)                   return RG_CH_B;
    else if (a >= ADR_GP_LO && a <= ADR_GP_HI) return RG_GP;
    else if (a == ADR_CTRL)                   return RG_CTRL;
    else                                      return RG_NONE;
  endfunction

endpackage

// File: rtl/dpot_i2c_tgt.sv
module dpot_i2c_tgt
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        addr_sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              ptr_we_o,
  output logic              wr_we_o,
  output logic              rd_adv_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  logic [2:0] scl_sr, sda_sr;
  logic scl_now, scl_old, sda_now, sda_old;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end
  end

  assign scl_now  = scl_sr[1];
  assign scl_old  = scl_sr[2];
  assign sda_now  = sda_sr[1];
  assign sda_old  = sda_sr[2];
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_ev = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_ev  = scl_now & scl_old & ~sda_old & sda_now;

  tgt_st_e           st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              first_q, first_d;
  logic              oe_q, oe_d;
  logic              ptr_we, wr_we, rd_adv;
  logic              addr_hit;

  assign addr_hit = (sh_q[7:1] == {DEV_PREFIX, addr_sel_i});

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    first_d = first_q;
    oe_d    = oe_q;
    ptr_we  = 1'b0;
    wr_we   = 1'b0;
    rd_adv  = 1'b0;
    if (stop_ev) begin
      st_d = T_IDLE;
      oe_d = 1'b0;
    end else if (start_ev) begin
      st_d  = T_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        T_ADDR, T_WRX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_now};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == T_ADDR) begin
              if (addr_hit) begin
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                first_d = 1'b1;
                st_d    = T_AACK;
              end else begin
                st_d = T_IDLE;
              end
            end else begin
              oe_d = 1'b1;
              st_d = T_WACK;
              if (first_q) begin
                ptr_we  = 1'b1;
                first_d = 1'b0;
              end else begin
                wr_we = 1'b1;
              end
            end
          end
        end
        T_AACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              st_d    = T_TX;
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[7];
              cnt_d   = 4'd1;
              first_d = 1'b0;
            end else begin
              st_d  = T_WRX;
              oe_d  = 1'b0;
              cnt_d = '0;
            end
          end
        end
        T_WACK: begin
          if (scl_fall) begin
            st_d  = T_WRX;
            oe_d  = 1'b0;
            cnt_d = '0;
          end
        end
        T_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d   = 1'b0;
              st_d   = T_TACK;
              rd_adv = 1'b1;
            end else begin
              oe_d  = ~sh_q[6];
              sh_d  = {sh_q[6:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        T_TACK: begin
          if (scl_rise && sda_now) begin
            st_d = T_IDLE;
          end else if (scl_fall) begin
            st_d  = T_TX;
            sh_d  = rd_data_i;
            oe_d  = ~rd_data_i[7];
            cnt_d = 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= T_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_we_o  = ptr_we;
  assign wr_we_o   = wr_we;
  assign rd_adv_o  = rd_adv;
  assign wr_data_o = sh_q;

  // R1
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T_AACK && oe_q) |->
      (sh_q[7:1] == {DEV_PREFIX, addr_sel_i}) && (sh_q[7:1] != 7'h00));

  // R2
  sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_now && scl_old && !start_ev && !stop_ev) |=> $stable(oe_q));

  // R2
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ptr_we, wr_we, rd_adv}) <= 1);

endmodule

// File: rtl/dpot_nv_store.sv
module dpot_nv_store
  import dpot_pkg::*;
#(
  parameter int              BYTES        = NV_BYTES,
  parameter int              BUSY_CYCLES  = 1000,
  parameter logic [BYTE_W-1:0] FACTORY_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [3:0]        waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [3:0]        raddr_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [BYTE_W-1:0] mem_q [BYTES];
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)               cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_cell
    localparam logic [BYTE_W-1:0] INIT = (g < 2) ? FACTORY_CODE : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem_q[g] <= INIT;
      else if (we_i && waddr_i == 4'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < BYTES) ? mem_q[raddr_i] : '0;
  assign busy_o  = (cnt_q != '0);

  // R7
  nv_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> busy_o);

  // R8
  nv_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> !busy_o);

endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int                NV_BUSY_CYCLES = 1000,
  parameter logic [BYTE_W-1:0] FACTORY_CODE   = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we_i,
  input  logic              wr_we_i,
  input  logic              rd_adv_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] wiper_a_o,
  output logic [BYTE_W-1:0] wiper_b_o,
  output logic              shutdown_o
);

  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] wa_q, wa_d, wb_q, wb_d;
  logic              vol_q, vol_d, shdn_q, shdn_d;
  logic              nv_we, nv_busy;
  logic [BYTE_W-1:0] nv_rd;
  region_e           rg;

  assign rg = region_of(ptr_q);

  always_comb begin
    ptr_d  = ptr_q;
    wa_d   = wa_q;
    wb_d   = wb_q;
    vol_d  = vol_q;
    shdn_d = shdn_q;
    nv_we  = 1'b0;
    if (ptr_we_i)                 ptr_d = wr_data_i;
    else if (wr_we_i || rd_adv_i) ptr_d = ptr_q + 8'd1;
    if (wr_we_i && !nv_busy) begin
      unique case (rg)
        RG_CH_A: begin wa_d = wr_data_i; nv_we = !vol_q; end
        RG_CH_B: begin wb_d = wr_data_i; nv_we = !vol_q; end
        RG_GP:   nv_we = !vol_q;
        RG_CTRL: begin vol_d = wr_data_i[7]; shdn_d = wr_data_i[6]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wa_q   <= FACTORY_CODE;
      wb_q   <= FACTORY_CODE;
      vol_q  <= 1'b0;
      shdn_q <= 1'b1;
    end else begin
      ptr_q  <= ptr_d;
      wa_q   <= wa_d;
      wb_q   <= wb_d;
      vol_q  <= vol_d;
      shdn_q <= shdn_d;
    end
  end

  dpot_nv_store #(
    .BYTES        (NV_BYTES),
    .BUSY_CYCLES  (NV_BUSY_CYCLES),
    .FACTORY_CODE (FACTORY_CODE)
  ) u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (nv_we),
    .waddr_i (ptr_q[3:0]),
    .wdata_i (wr_data_i),
    .raddr_i (ptr_q[3:0]),
    .rdata_o (nv_rd),
    .busy_o  (nv_busy)
  );

  always_comb begin
    unique case (rg)
      RG_CH_A: rd_data_o = vol_q ? wa_q : nv_rd;
      RG_CH_B: rd_data_o = vol_q ? wb_q : nv_rd;
      RG_GP:   rd_data_o = vol_q ? '0 : nv_rd;
      RG_CTRL: rd_data_o = {vol_q, shdn_q, nv_busy, 5'b00000};
      default: rd_data_o = '0;
    endcase
  end

  assign wiper_a_o  = wa_q;
  assign wiper_b_o  = wb_q;
  assign shutdown_o = ~shdn_q;

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_we_i || rd_adv_i) && !ptr_we_i) |=> (ptr_q == $past(ptr_q) + 8'd1));

  // R6
  nv_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we_i && rg == RG_CH_A && !vol_q && !nv_busy) |=>
      (wiper_a_o == $past(wr_data_i)) && nv_busy);

  // R8
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we_i && nv_busy) |=> ($stable(vol_q) && $stable(shdn_q) &&
                              $stable(wiper_a_o) && $stable(wiper_b_o)));

  // R10
  ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rg == RG_CTRL) |-> (rd_data_o[4:0] == 5'b00000));

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int                NV_BUSY_CYCLES = 1000,
  parameter logic [BYTE_W-1:0] FACTORY_CODE   = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        addr_sel_i,
  output logic [BYTE_W-1:0] wiper_a_o,
  output logic [BYTE_W-1:0] wiper_b_o,
  output logic              shutdown_o
);

  logic [1:0]        rst_sr;
  logic              rst_sync_n;
  logic              ptr_we, wr_we, rd_adv;
  logic [BYTE_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_sync_n = rst_sr[1];

  dpot_i2c_tgt u_tgt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .addr_sel_i (addr_sel_i),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .ptr_we_o   (ptr_we),
    .wr_we_o    (wr_we),
    .rd_adv_o   (rd_adv),
    .wr_data_o  (wr_data)
  );

  dpot_regs #(
    .NV_BUSY_CYCLES (NV_BUSY_CYCLES),
    .FACTORY_CODE   (FACTORY_CODE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ptr_we_i   (ptr_we),
    .wr_we_i    (wr_we),
    .rd_adv_i   (rd_adv),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .wiper_a_o  (wiper_a_o),
    .wiper_b_o  (wiper_b_o),
    .shutdown_o (shutdown_o)
  );

endmodule

// File: tb/dpot_ctrl_bench.sv
module dpot_ctrl_bench;

  localparam int BUSY = 4000;
  localparam int H    = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] sel = 3'b101;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] wa, wb;
  logic       shut;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  localparam logic [7:0] DEV_W = {4'b1010, 3'b101, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, 3'b101, 1'b1};

  always #5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  dpot_ctrl #(.NV_BUSY_CYCLES(BUSY)) u_dpot_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .addr_sel_i (sel),
    .wiper_a_o  (wa),
    .wiper_b_o  (wb),
    .shutdown_o (shut)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b0; hp();
    m_scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp();
      m_scl = 1'b1; hp();
      m_scl = 1'b0;
    end
    m_sda = 1'b1; hp();
    m_scl = 1'b1;
    repeat (H / 2) @(negedge clk);
    ack = ~sda_bus;
    repeat (H / 2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp();
      m_scl = 1'b1;
      repeat (H / 2) @(negedge clk);
      b[i] = sda_bus;
      repeat (H / 2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = last; hp();
    m_scl = 1'b1; hp();
    m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic acks);
    logic k0, k1, k2;
    bus_start();
    send_byte(DEV_W, k0);
    send_byte(a, k1);
    send_byte(d, k2);
    bus_stop();
    acks = k0 & k1 & k2;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    logic k;
    bus_start();
    send_byte(DEV_W, k);
    send_byte(a, k);
    bus_start();
    send_byte(DEV_R, k);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R4 wiper A", wa, 8'h80);
    chk("R4 wiper B", wb, 8'h80);
    chk("R4 shutdown", {7'd0, shut}, 8'h00);
    rd_reg(8'h10, d); chk("R4 R10 ctrl", d, 8'h40);
    rd_reg(8'h00, d); chk("R4 init A", d, 8'h80);
    rd_reg(8'h01, d); chk("R4 init B", d, 8'h80);
  endtask

  task automatic t_addr();
    logic k;
    bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, k); bus_stop();
    chk("R1 wrong pins nack", {7'd0, k}, 8'h00);
    bus_start(); send_byte(8'h00, k); bus_stop();
    chk("R1 general call nack", {7'd0, k}, 8'h00);
    bus_start(); send_byte(8'h70, k); bus_stop();
    chk("R1 other prefix nack", {7'd0, k}, 8'h00);
    bus_start(); send_byte(DEV_W, k); bus_stop();
    chk("R1 match ack", {7'd0, k}, 8'h01);
  endtask

  task automatic t_nv_write();
    logic k;
    logic [7:0] d;
    wr_reg(8'h00, 8'h30, k);
    chk("R2 write acks", {7'd0, k}, 8'h01);
    chk("R6 mirror wiper A", wa, 8'h30);
    rd_reg(8'h10, d); chk("R7 WIP set", d, 8'h60);
    wr_reg(8'h01, 8'h99, k);
    chk("R8 refused write acked", {7'd0, k}, 8'h01);
    chk("R8 wiper B locked", wb, 8'h80);
    wr_reg(8'h10, 8'h80, k);
    rd_reg(8'h10, d); chk("R8 ctrl locked", d, 8'h60);
    repeat (BUSY + 200) @(negedge clk);
    rd_reg(8'h10, d); chk("R7 WIP clear", d, 8'h40);
    rd_reg(8'h01, d); chk("R8 init B unchanged", d, 8'h80);
    rd_reg(8'h00, d); chk("R6 init A stored", d, 8'h30);
  endtask

  task automatic t_vol();
    logic k;
    logic [7:0] d;
    wr_reg(8'h10, 8'hC0, k);
    rd_reg(8'h10, d); chk("R5 vol mode set", d, 8'hC0);
    wr_reg(8'h00, 8'h11, k);
    chk("R5 wiper A written", wa, 8'h11);
    rd_reg(8'h00, d); chk("R5 wiper A read", d, 8'h11);
    rd_reg(8'h10, d); chk("R5 no NV write", d, 8'hC0);
    wr_reg(8'h05, 8'h77, k);
    rd_reg(8'h05, d); chk("R11 GP vol read", d, 8'h00);
    wr_reg(8'h10, 8'h40, k);
    rd_reg(8'h00, d); chk("R5 init A kept", d, 8'h30);
    chk("R5 wiper A kept", wa, 8'h11);
    rd_reg(8'h05, d); chk("R11 GP vol write dropped", d, 8'h00);
  endtask

  task automatic t_gp();
    logic k;
    logic [7:0] d;
    wr_reg(8'h07, 8'hA5, k);
    repeat (BUSY + 200) @(negedge clk);
    rd_reg(8'h07, d); chk("R11 GP store", d, 8'hA5);
    rd_reg(8'h0E, d); chk("R11 GP top byte", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic k;
    logic [7:0] d;
    wr_reg(8'h0F, 8'hFF, k);
    chk("R12 reserved acked", {7'd0, k}, 8'h01);
    rd_reg(8'h0F, d); chk("R12 reserved read", d, 8'h00);
    rd_reg(8'h10, d); chk("R12 no busy", d, 8'h40);
    wr_reg(8'h1F, 8'h5A, k);
    rd_reg(8'h1F, d); chk("R12 unmapped read", d, 8'h00);
  endtask

  task automatic t_burst();
    logic k;
    logic [7:0] d0, d1;
    wr_reg(8'h10, 8'hC0, k);
    bus_start();
    send_byte(DEV_W, k);
    send_byte(8'h00, k);
    send_byte(8'h22, k);
    send_byte(8'h44, k);
    bus_stop();
    chk("R3 burst wiper A", wa, 8'h22);
    chk("R3 burst wiper B", wb, 8'h44);
    bus_start();
    send_byte(DEV_W, k);
    send_byte(8'h00, k);
    bus_start();
    send_byte(DEV_R, k);
    recv_byte(1'b0, d0);
    recv_byte(1'b1, d1);
    bus_stop();
    chk("R3 burst read first", d0, 8'h22);
    chk("R3 burst read second", d1, 8'h44);
  endtask

  task automatic t_shdn();
    logic k;
    logic [7:0] d;
    wr_reg(8'h10, 8'h80, k);
    chk("R9 shutdown on", {7'd0, shut}, 8'h01);
    wr_reg(8'h10, 8'hFF, k);
    chk("R9 shutdown off", {7'd0, shut}, 8'h00);
    rd_reg(8'h10, d); chk("R10 low bits and WIP ignored", d, 8'hC0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_addr();
    t_nv_write();
    t_vol();
    t_gp();
    t_unmapped();
    t_burst();
    t_shdn();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule